// File: doc/BRIEF.md
# Half-Bit Period Calibrator

This block measures the true half-bit period (TE) of an incoming Manchester-coded frame in system clock cycles. A receiver uses the result to retune its sampling rate, so reception keeps working when the transmitter's bit rate or the local clock drifts. After the start bit has been detected, an arm pulse readies the unit. It then measures two widths on the synchronized line: the first high pulse, and that high pulse together with the low pulse that follows it.

A slow rising edge shortens the measured high pulse. The low pulse gains by the same amount, so the sum of the two is a whole multiple of TE. The block does not use the high pulse on its own. It looks at the low width to decide whether the low pulse covers one half-bit or two. It then divides the total by 2 or by 3 with a small iterative divider. The result is computed only once the frame-end pulse arrives, so the period in use never changes in the middle of a frame. A measurement with a saturated counter, or one that never completed, is discarded and the previous period stays in force.

Top module: `halfbit_cal`

## Requirements
- R1: While reset is asserted and until the first update, te_o equals CLK_HZ / SAMPLE_HZ rounded down, and te_valid_o is 0.
- R2: The high width counts one per clock in which line_i is sampled 1. Counting starts with the first clock after an arm pulse in which line_i is 1 and was 0 in the previous clock.
- R3: The total width is the high width plus the number of following consecutive clocks in which line_i is sampled 0. It ends when line_i is next sampled 1.
- R4: If twice the low width (total minus high) is strictly greater than three times the high width, the new TE is floor(total / 3).
- R5: Otherwise, including the case where the two are equal, the new TE is floor(total / 2).
- R6: te_o changes only while te_valid_o is high. te_valid_o is a one-clock pulse that goes high exactly CNT_W + 1 clocks after the clock in which frame_end_i is sampled high with a completed measurement.
- R7: Both counters saturate at 2^CNT_W − 1. A measurement in which either counter hit saturation gives no te_valid_o pulse and leaves te_o unchanged.
- R8: A frame_end_i that arrives before the total width has completed gives no te_valid_o pulse and leaves te_o unchanged.
- R9: A frame_end_i that arrives while a division is still running is ignored. Only the running result is delivered.
- R10: An arm pulse in the middle of a measurement discards the partial widths and starts again with a fresh wait for a rising edge.
- R11: The result tracks line rates from half to double the nominal rate, with TE from 2×NOM down to NOM/2. The default CNT_W of 20 holds 6× the nominal TE at the default clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| line_i | input | 1 | Synchronized receive line level |
| arm_i | input | 1 | One-clock pulse once the start bit has been seen |
| frame_end_i | input | 1 | One-clock pulse when the end of the frame has been detected |
| te_o | output | CNT_W | Current half-bit period in clock cycles |
| te_valid_o | output | 1 | One-clock pulse that marks an updated te_o |

## Verification
The assertions assume that arm_i and frame_end_i are single-clock pulses that never arrive together, and that line_i is already synchronized to clk. The stimulus raises arm_i only while the line is low and never pulses the two controls in the same clock. Line pulse widths are chosen around the equality boundary of the one-or-two half-bit decision, at odd totals that exercise truncation, and at half and double the nominal rate. A pulse longer than the counter range exercises saturation. Interfering arm and frame-end pulses are placed in the middle of a measurement and in the middle of a division.

// File: rtl/hbc_pkg.sv
package hbc_pkg;
  typedef enum logic [2:0] {
    MS_IDLE,
    MS_WAIT,
    MS_HIGH,
    MS_LOW,
    MS_DONE
  } meas_st_e;
endpackage

// File: rtl/hbc_measure.sv
module hbc_measure
  import hbc_pkg::*;
#(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  input  logic             arm_i,
  input  logic             frame_end_i,
  output logic [CNT_W-1:0] hi_o,
  output logic [CNT_W-1:0] tot_o,
  output logic             complete_o,
  output logic             sat_o
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  meas_st_e         st_q, st_d;
  logic [CNT_W-1:0] hi_q, hi_d, tot_q, tot_d;
  logic             sat_q, sat_d, prev_q;
  logic             rise;

  assign rise = line_i & ~prev_q;

  always_comb begin
    st_d  = st_q;
    hi_d  = hi_q;
    tot_d = tot_q;
    sat_d = sat_q;
    if (arm_i) begin
      st_d  = MS_WAIT;
      hi_d  = '0;
      tot_d = '0;
      sat_d = 1'b0;
    end else if (frame_end_i) begin
      st_d = MS_IDLE;
    end else begin
      case (st_q)
        MS_WAIT: if (rise) begin
          st_d  = MS_HIGH;
          hi_d  = CNT_W'(1);
          tot_d = CNT_W'(1);
        end
        MS_HIGH: begin
          if (tot_q == CMAX) sat_d = 1'b1;
          else               tot_d = tot_q + 1'b1;
          if (line_i) begin
            if (hi_q == CMAX) sat_d = 1'b1;
            else              hi_d  = hi_q + 1'b1;
          end else begin
            st_d = MS_LOW;
          end
        end
        MS_LOW: begin
          if (line_i) st_d = MS_DONE;
          else if (tot_q == CMAX) sat_d = 1'b1;
          else tot_d = tot_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= MS_IDLE;
      hi_q   <= '0;
      tot_q  <= '0;
      sat_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      hi_q   <= hi_d;
      tot_q  <= tot_d;
      sat_q  <= sat_d;
      prev_q <= line_i;
    end
  end

  assign hi_o       = hi_q;
  assign tot_o      = tot_q;
  assign complete_o = (st_q == MS_DONE);
  assign sat_o      = sat_q;

  a_r10_arm_restart: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> (st_q == MS_WAIT && hi_q == '0 && tot_q == '0 && !sat_q));
  a_r3_total_exceeds_high: assert property (@(posedge clk) disable iff (!rst_n)
    (complete_o && !sat_q) |-> (hi_q != '0 && tot_q > hi_q));
  a_r7_sat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_q && !arm_i) |=> sat_q);
endmodule

// File: rtl/hbc_div.sv
module hbc_div #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic         by3_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quo_o
);
  localparam int CW = $clog2(W + 1);

  logic          busy_q, busy_d, done_q, done_d, by3_q, by3_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    rem_q, rem_d;
  logic [W-1:0]  quo_q, quo_d, dvd_q, dvd_d;
  logic [2:0]    trial, dv;
  logic          ge;

  assign trial = {rem_q, quo_q[W-1]};
  assign dv    = by3_q ? 3'd3 : 3'd2;
  assign ge    = (trial >= dv);

  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    by3_d  = by3_q;
    cnt_d  = cnt_q;
    rem_d  = rem_q;
    quo_d  = quo_q;
    dvd_d  = dvd_q;
    if (start_i && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = CW'(W);
      rem_d  = 2'd0;
      quo_d  = dividend_i;
      dvd_d  = dividend_i;
      by3_d  = by3_i;
    end else if (busy_q) begin
      rem_d = ge ? 2'(trial - dv) : trial[1:0];
      quo_d = {quo_q[W-2:0], ge};
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      by3_q  <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvd_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      by3_q  <= by3_d;
      cnt_q  <= cnt_d;
      rem_q  <= rem_d;
      quo_q  <= quo_d;
      dvd_q  <= dvd_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quo_o  = quo_q;

  // R4 / R5: the quotient and remainder reconstruct the latched dividend
  a_r4_quot_exact: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (({2'b00, quo_q} * (W+2)'(dv) + (W+2)'(rem_q)) == {2'b00, dvd_q}
                && {1'b0, rem_q} < dv));
  a_r9_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i) |=> ($stable(dvd_q) && $stable(by3_q)));
endmodule

// File: rtl/halfbit_cal.sv
module halfbit_cal #(
  parameter int CLK_HZ    = 125_000_000,
  parameter int SAMPLE_HZ = 2400,
  parameter int CNT_W     = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  input  logic             arm_i,
  input  logic             frame_end_i,
  output logic [CNT_W-1:0] te_o,
  output logic             te_valid_o
);
  localparam int CMP_W = CNT_W + 2;
  localparam logic [CNT_W-1:0] TE_NOM = CNT_W'(CLK_HZ / SAMPLE_HZ);

  logic [CNT_W-1:0] hi, tot, quo;
  logic             complete, sat, busy, done;
  logic [CMP_W-1:0] lo_x2, hi_x3;
  logic             by3, start;
  logic [CNT_W-1:0] te_q, te_d;
  logic             vld_q;

  hbc_measure #(.CNT_W(CNT_W)) u_meas (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .arm_i(arm_i),
    .frame_end_i(frame_end_i), .hi_o(hi), .tot_o(tot),
    .complete_o(complete), .sat_o(sat)
  );

  assign lo_x2 = {1'b0, (tot - hi), 1'b0};
  assign hi_x3 = CMP_W'(hi) + {1'b0, hi, 1'b0};
  assign by3   = (lo_x2 > hi_x3);
  assign start = frame_end_i & complete & ~sat;

  hbc_div #(.W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start_i(start), .dividend_i(tot),
    .by3_i(by3), .busy_o(busy), .done_o(done), .quo_o(quo)
  );

  always_comb begin
    te_d = te_q;
    if (done) te_d = quo;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      te_q  <= TE_NOM;
      vld_q <= 1'b0;
    end else begin
      te_q  <= te_d;
      vld_q <= done;
    end
  end

  assign te_o       = te_q;
  assign te_valid_o = vld_q;

  a_r6_te_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !te_valid_o |-> $stable(te_o));
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    te_valid_o |=> !te_valid_o);
  a_r9_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

// File: tb/halfbit_cal_bench.sv
module halfbit_cal_bench;
  localparam int CLK_HZ = 240_000;
  localparam int SMP_HZ = 2400;
  localparam int W      = 12;
  localparam int NOM    = CLK_HZ / SMP_HZ;
  localparam int MAXC   = (1 << W) - 1;

  logic         clk, rst_n, line, arm, fend;
  logic [W-1:0] te;
  logic         te_valid;

  int checks = 0, errors = 0, cycles = 0, vcount = 0;

  halfbit_cal #(.CLK_HZ(CLK_HZ), .SAMPLE_HZ(SMP_HZ), .CNT_W(W)) u_halfbit_cal (
    .clk(clk), .rst_n(rst_n), .line_i(line), .arm_i(arm),
    .frame_end_i(fend), .te_o(te), .te_valid_o(te_valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural reference model: 0 idle, 1 wait, 2 high, 3 low, 4 done
  int phase, hi_m, tot_m, pend, pval, te_exp;
  bit prev_m, sat_m, vexp;

  always @(posedge clk) begin
    if (!rst_n) begin
      phase = 0; hi_m = 0; tot_m = 0; sat_m = 0; prev_m = 0;
      pend = 0; pval = 0; te_exp = NOM; vexp = 0;
    end else begin
      automatic int pbefore = pend;
      vexp = 0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin te_exp = pval; vexp = 1; end
      end
      if (fend && phase == 4 && !sat_m && pbefore <= 1) begin
        pend = W + 1;
        pval = (2 * (tot_m - hi_m) > 3 * hi_m) ? tot_m / 3 : tot_m / 2;
      end
      if (arm) begin
        phase = 1; hi_m = 0; tot_m = 0; sat_m = 0;
      end else if (fend) begin
        phase = 0;
      end else begin
        case (phase)
          1: if (line && !prev_m) begin phase = 2; hi_m = 1; tot_m = 1; end
          2: begin
            if (tot_m == MAXC) sat_m = 1; else tot_m++;
            if (line) begin
              if (hi_m == MAXC) sat_m = 1; else hi_m++;
            end else phase = 3;
          end
          3: begin
            if (line) phase = 4;
            else if (tot_m == MAXC) sat_m = 1;
            else tot_m++;
          end
          default: ;
        endcase
      end
      prev_m = line;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk("R6 te vs model", int'(te), te_exp);
      chk("R6 valid vs model", int'(te_valid), int'(vexp));
      if (te_valid) vcount++;
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic frame(int pre, int h, int l, int tail, int post);
    line = 1'b0; arm = 1'b1; step(1);
    arm = 1'b0; step(pre);
    line = 1'b1; step(h);
    line = 1'b0; step(l);
    line = 1'b1; step(tail);
    fend = 1'b1; step(1);
    fend = 1'b0; step(post);
  endtask

  initial begin
    automatic int v0;
    rst_n = 1'b0; line = 1'b1; arm = 1'b0; fend = 1'b0;
    step(3);
    chk("R1 reset te", int'(te), NOM);
    chk("R1 reset valid", int'(te_valid), 0);
    rst_n = 1'b1; step(2);
    chk("R1 te after release", int'(te), NOM);

    frame(3, 45, 55, 4, W + 4);
    chk("R5 R11 double rate", int'(te), 50);
    frame(3, 190, 410, 4, W + 4);
    chk("R4 R11 half rate", int'(te), 200);
    frame(3, 70, 81, 4, W + 4);
    chk("R5 odd total floor", int'(te), 75);
    frame(3, 66, 134, 4, W + 4);
    chk("R4 floor of third", int'(te), 66);
    frame(3, 40, 60, 4, W + 4);
    chk("R5 equality boundary", int'(te), 50);
    frame(3, 40, 61, 4, W + 4);
    chk("R4 R2 R3 just above boundary", int'(te), 33);

    v0 = vcount;
    frame(3, MAXC + 105, 50, 4, W + 4);
    chk("R7 saturated te kept", int'(te), 33);
    chk("R7 saturated no pulse", vcount - v0, 0);

    v0 = vcount;
    line = 1'b0; arm = 1'b1; step(1); arm = 1'b0; step(3);
    line = 1'b1; step(40); line = 1'b0; step(20);
    fend = 1'b1; step(1); fend = 1'b0; line = 1'b1; step(W + 4);
    chk("R8 early end te kept", int'(te), 33);
    chk("R8 early end no pulse", vcount - v0, 0);

    v0 = vcount;
    frame(3, 90, 110, 4, 0);
    frame(1, 2, 3, 1, W + 6);
    chk("R9 busy end ignored te", int'(te), 100);
    chk("R9 single pulse", vcount - v0, 1);

    line = 1'b0; arm = 1'b1; step(1); arm = 1'b0; step(2);
    line = 1'b1; step(30); line = 1'b0; step(2);
    frame(3, 47, 53, 4, W + 4);
    chk("R10 rearm result", int'(te), 50);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule